// File: doc/BRIEF.md
# I2C Bus Interval and Hang Timer

This block is the timing companion of an I2C bus engine. It holds one counter that moves forward on each machine-cycle strobe. The three low-order bits of the counter give the short minimum intervals the engine must respect: SCL high and low times, the stop setup, the bus-free gap and the start hold. The full counter works as a watchdog for a hung bus. It is reloaded on every SCL transition, and it runs only while a frame is open, from a start until the next stop. When it runs out, the block sends a one-cycle reset pulse to the bus interface, which releases SCL. The same pulse can also raise an interrupt request.

The bus engine provides an already synchronized SCL level and single-cycle start and stop detect pulses. From its configuration it provides a run-enable bit, a two-bit prescale code and the timer interrupt enable. The prescale code sets the value loaded into the low bits. This lets the engine trim both the minimum-interval period and the exact timeout length to suit the clock frequency.

Top module: `i2c_bus_timer`

## Requirements
- R1: While `run_en` is 1 and a frame is open, the count `tmr_cnt` rises by exactly one on each clock edge where `cyc_en` is 1, and it holds when `cyc_en` is 0.
- R2: While `run_en` is 1, a change of `scl_sync` inside a frame, or a `start_det` pulse, loads `tmr_cnt` with the preload value one clock later.
- R3: Outside a frame `tmr_cnt` stays at 0, including when SCL toggles. A `stop_det` pulse closes the frame and clears the count. When `start_det` and `stop_det` arrive in the same cycle, the stop wins and no frame opens.
- R4: If no reload happens, `iface_rst` goes to 1 for exactly one cycle after 1023 − preload counting strobes from the last load. On that cycle `tmr_cnt` is 0 and the frame is closed.
- R5: `tmr_irq` pulses together with `iface_rst` only when `irq_en` is 1. It stays at 0 otherwise.
- R6: While `run_en` is 0 the count is frozen: strobes and SCL changes have no effect, and no interface reset occurs.
- R7: The preload value equals the prescale code: codes 0, 1, 2 and 3 load 0, 1, 2 and 3.
- R8: `min_done` pulses for one cycle when the low three bits of the count wrap from 7 to 0. This happens 8 − preload strobes after a load, and on that cycle `tmr_cnt[2:0]` is 0.
- R9: After reset, `tmr_cnt` is 0, no frame is open, and `iface_rst`, `tmr_irq` and `min_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Machine-cycle strobe, one count per high cycle |
| run_en | input | 1 | Timer run enable |
| prescale | input | 2 | Preload select for the low bits |
| irq_en | input | 1 | Timer interrupt enable |
| scl_sync | input | 1 | Synchronized SCL level |
| start_det | input | 1 | Start condition pulse from bus engine |
| stop_det | input | 1 | Stop condition pulse from bus engine |
| tmr_cnt | output | 10 | Current counter value |
| min_done | output | 1 | Minimum-interval elapsed pulse |
| iface_rst | output | 1 | Bus interface reset pulse on timeout |
| tmr_irq | output | 1 | Timeout interrupt request pulse |

## Verification
Counting is tried with a steady strobe and with a strobe high only every other cycle. This separates a count of strobes from a count of clocks. The timeout length is measured with the smallest and largest preload and the interrupt enabled and disabled. This pins down the off-by-one of the carry point and the irq gating. An SCL toggle in mid-frame, toggles outside a frame, and toggles with the timer disabled show that a reload happens only while the timer runs inside a frame. Simultaneous start and stop pulses check the priority of the stop.

// File: rtl/i2c_tmr_pkg.sv
package i2c_tmr_pkg;
  // Preload value for the low bits, taken from the prescale code (R7)
  function automatic logic [2:0] preload_of(input logic [1:0] code);
    return {1'b0, code};
  endfunction

  // Low bits about to wrap to zero on the next count
  function automatic logic low_wraps(input logic [2:0] low);
    return &low;
  endfunction
endpackage

// File: rtl/i2c_scl_edge.sv
module i2c_scl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_sync,
  output logic scl_edge
);
  logic scl_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) scl_prev <= 1'b1;
    else        scl_prev <= scl_sync;
  end

  assign scl_edge = scl_sync ^ scl_prev;
endmodule

// File: rtl/i2c_frame_track.sv
module i2c_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic abort,
  output logic in_frame
);
  always_ff @(posedge clk) begin
    if (!rst_n)                in_frame <= 1'b0;
    else if (stop_det || abort) in_frame <= 1'b0;
    else if (start_det)        in_frame <= 1'b1;
  end

  // R3
  stop_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !in_frame);
endmodule

// File: rtl/i2c_tmr_core.sv
module i2c_tmr_core
  import i2c_tmr_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int LOW_W = 3,
  parameter int PS_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             clear,
  input  logic [PS_W-1:0]  prescale,
  input  logic             irq_en,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             iface_rst,
  output logic             tmr_irq,
  output logic             min_done
);
  localparam logic [CNT_W-1:0] LAST = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] preload_val;
  logic             advance;
  logic             wrap_low;

  assign preload_val = {{(CNT_W-LOW_W){1'b0}}, preload_of(prescale)};
  assign advance     = tick && !load && !clear;
  assign expire      = advance && (cnt == LAST);
  assign wrap_low    = advance && low_wraps(cnt[LOW_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      iface_rst <= 1'b0;
      tmr_irq   <= 1'b0;
      min_done  <= 1'b0;
    end else begin
      iface_rst <= expire;
      tmr_irq   <= expire && irq_en;
      min_done  <= wrap_low;
      if (clear)        cnt <= '0;
      else if (load)    cnt <= preload_val;
      else if (expire)  cnt <= '0;
      else if (tick)    cnt <= cnt + 1'b1;
    end
  end

  // R4
  rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iface_rst |=> !iface_rst);
  // R4
  rst_zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iface_rst |-> (cnt == '0));
  // R5
  irq_with_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |-> iface_rst);
  // R8
  min_done_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    min_done |-> (cnt[LOW_W-1:0] == '0));
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !expire) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/i2c_bus_timer.sv
module i2c_bus_timer #(
  parameter int CNT_W = 10,
  parameter int LOW_W = 3,
  parameter int PS_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             run_en,
  input  logic [PS_W-1:0]  prescale,
  input  logic             irq_en,
  input  logic             scl_sync,
  input  logic             start_det,
  input  logic             stop_det,
  output logic [CNT_W-1:0] tmr_cnt,
  output logic             min_done,
  output logic             iface_rst,
  output logic             tmr_irq
);
  logic scl_edge;
  logic in_frame;
  logic expire;
  logic tick;
  logic load;

  i2c_scl_edge u_edge (
    .clk(clk), .rst_n(rst_n), .scl_sync(scl_sync), .scl_edge(scl_edge)
  );

  i2c_frame_track u_frame (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .abort(expire), .in_frame(in_frame)
  );

  assign tick = run_en && in_frame && cyc_en;
  assign load = run_en && (start_det || (scl_edge && in_frame));

  i2c_tmr_core #(.CNT_W(CNT_W), .LOW_W(LOW_W), .PS_W(PS_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .clear(stop_det),
    .prescale(prescale), .irq_en(irq_en), .cnt(tmr_cnt), .expire(expire),
    .iface_rst(iface_rst), .tmr_irq(tmr_irq), .min_done(min_done)
  );

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |-> (tmr_cnt == '0));
  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !stop_det) |=> $stable(tmr_cnt));
  // R2
  scl_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && in_frame && scl_edge && !stop_det) |=>
      (tmr_cnt == {{(CNT_W-PS_W){1'b0}}, $past(prescale)}));
  // R4
  expire_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!in_frame && iface_rst));
endmodule

// File: tb/i2c_bus_timer_test.sv
module i2c_bus_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b1;
  logic       run_en = 1'b1;
  logic [1:0] prescale = 2'd0;
  logic       irq_en = 1'b1;
  logic       scl_sync = 1'b1;
  logic       start_det = 1'b0;
  logic       stop_det = 1'b0;
  logic [9:0] tmr_cnt;
  logic       min_done, iface_rst, tmr_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  i2c_bus_timer uut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .run_en(run_en),
    .prescale(prescale), .irq_en(irq_en), .scl_sync(scl_sync),
    .start_det(start_det), .stop_det(stop_det), .tmr_cnt(tmr_cnt),
    .min_done(min_done), .iface_rst(iface_rst), .tmr_irq(tmr_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic open_frame(input int p);
    @(negedge clk); prescale = p[1:0]; start_det = 1'b1;
    @(negedge clk); start_det = 1'b0;
  endtask

  task automatic close_frame();
    @(negedge clk); stop_det = 1'b1;
    @(negedge clk); stop_det = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R9 cnt", tmr_cnt, 0);
    check("R9 iface_rst", iface_rst, 0);
    check("R9 tmr_irq", tmr_irq, 0);
    check("R9 min_done", min_done, 0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 6; i++) begin @(negedge clk); scl_sync = ~scl_sync; end
    scl_sync = 1'b1;
    wait_n(3);
    check("R3 idle cnt", tmr_cnt, 0);
  endtask

  task automatic t_preload();
    for (int p = 0; p < 4; p++) begin
      open_frame(p);
      check("R7 preload", tmr_cnt, p);
      wait_n(5);
      check("R1 count", tmr_cnt, p + 5);
      close_frame();
      check("R3 stop clears", tmr_cnt, 0);
      wait_n(3);
      check("R3 stays zero", tmr_cnt, 0);
    end
  endtask

  task automatic t_scl_clear();
    open_frame(1);
    wait_n(20);
    check("R2 before edge", tmr_cnt, 21);
    scl_sync = 1'b0;
    @(negedge clk);
    check("R2 reload", tmr_cnt, 1);
    wait_n(3);
    check("R2 after reload", tmr_cnt, 4);
    scl_sync = 1'b1;
    close_frame();
  endtask

  task automatic t_timeout(input int p, input bit irq);
    int k = 0;
    int irq_seen = 0;
    irq_en = irq;
    open_frame(p);
    while (!iface_rst && k < 2000) begin @(negedge clk); k++; end
    irq_seen = tmr_irq;
    check("R4 timeout length", k, 1023 - p);
    check("R4 cnt at reset", tmr_cnt, 0);
    check("R5 irq gating", irq_seen, irq ? 1 : 0);
    @(negedge clk);
    check("R4 one cycle", iface_rst, 0);
    wait_n(2);
    check("R4 frame closed", tmr_cnt, 0);
    irq_en = 1'b1;
  endtask

  task automatic t_min_done();
    int k = 0;
    open_frame(2);
    while (!min_done && k < 50) begin @(negedge clk); k++; end
    check("R8 interval", k, 6);
    check("R8 low bits", int'(tmr_cnt[2:0]), 0);
    @(negedge clk);
    check("R8 pulse", min_done, 0);
    close_frame();
  endtask

  task automatic t_run_off();
    int seen = 0;
    open_frame(0);
    wait_n(10);
    check("R1 pre freeze", tmr_cnt, 10);
    run_en = 1'b0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); scl_sync = ~scl_sync; end
    scl_sync = 1'b1;
    wait_n(2);
    check("R6 frozen", tmr_cnt, 10);
    for (int i = 0; i < 1100; i++) begin @(negedge clk); if (iface_rst) seen++; end
    check("R6 no reset", seen, 0);
    run_en = 1'b1;
    close_frame();
  endtask

  task automatic t_strobe();
    open_frame(0);
    for (int i = 0; i < 20; i++) begin
      cyc_en = (i % 2 == 0);
      @(negedge clk);
    end
    cyc_en = 1'b1;
    check("R1 strobe count", tmr_cnt, 10);
    close_frame();
  endtask

  task automatic t_start_stop();
    @(negedge clk); start_det = 1'b1; stop_det = 1'b1;
    @(negedge clk); start_det = 1'b0; stop_det = 1'b0;
    wait_n(5);
    check("R3 stop wins", tmr_cnt, 0);
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_idle();
    t_preload();
    t_scl_clear();
    t_timeout(0, 1'b1);
    t_timeout(3, 1'b0);
    t_min_done();
    t_run_off();
    t_strobe();
    t_start_stop();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule